// File: doc/BRIEF.md
# Six-Step Hall Commutation Decoder with PWM Gating

This block sits between three rotor-position sensors and a three-phase inverter. It turns the 3-bit Hall code into one high-side and one low-side switch command. A direction input picks the rotation sense. A synchronous chopping flag modulates the bridge. A quadrant selector decides whether chopping acts only on the low-side switches or on both rows. Dead time, sensor filtering and the analog comparators that produce the chopping and over-current flags live outside this block.

Several override conditions share one fixed priority, from highest to lowest:

1. Undervoltage lockout.
2. Coast.
3. Over-current blanking.
4. Brake.
5. Normal commutation.

Over-current works pulse by pulse. One over-current sample blanks the bridge until the chopping flag next rises. All six commands come from a register, so each output follows its inputs one clock later.

Top module: `hall_commutator`

## Requirements
- R1: While `rst_n` is low, every bit of `hs_cmd` and `ls_cmd` is 0.
- R2: Commands appear one clock edge after the inputs that cause them. Take `dir_fwd`=1, `pwm_on`=1, no override active and Hall code {C,B,A}. The code maps to a (sourced, sunk) phase pair as follows: 001→(A,B), 011→(A,C), 010→(B,C), 110→(B,A), 100→(C,A), 101→(C,B). Bit 0 of every vector is phase A, bit 1 is phase B and bit 2 is phase C.
- R3: With `dir_fwd`=0, the same Hall codes swap the sourced and sunk phases of the R2 pairs.
- R4: Hall code 000 or 111 with `brake_req`=0 drives all six commands off.
- R5: `brake_req`=1 with no higher-priority override turns all high-side commands off. It turns all three low-side commands on while `pwm_on`=1 and all off while `pwm_on`=0, whatever the Hall code.
- R6: With `four_quad`=0 and `pwm_on`=0, the low-side commands are off and the high-side command still follows the R2/R3 table.
- R7: With `four_quad`=1 and `pwm_on`=0, both rows are off. With `pwm_on`=1 the table applies unchanged.
- R8: `coast_req`=1 forces all six commands off and overrides brake.
- R9: `uv_lock`=1 forces all six commands off and overrides brake and coast release.
- R10: A sample with `oc_flag`=1 blanks all commands from the next edge. Blanking holds through later samples until a sample where `pwm_on` rises (low at the previous sample, high now) and `oc_flag`=0.
- R11: No phase ever has both its high-side and low-side command on, and at most one high-side command is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall | input | 3 | Rotor position code, bit 0 = phase A sensor |
| dir_fwd | input | 1 | 1 = forward sequence, 0 = reversed |
| brake_req | input | 1 | Brake: all low-side on, high-side off |
| coast_req | input | 1 | Coast: all commands off |
| four_quad | input | 1 | 1 = chop both rows, 0 = chop low side only |
| pwm_on | input | 1 | Synchronous chopping flag, 1 = on interval |
| oc_flag | input | 1 | Over-current sample from the sense comparator |
| uv_lock | input | 1 | Supply undervoltage lockout |
| hs_cmd | output | 3 | High-side switch commands, bit 0 = phase A |
| ls_cmd | output | 3 | Low-side switch commands, bit 0 = phase A |

## Verification
The only internal state is the previous chopping flag and the blanking latch. Outside those, a wrong decode or a wrong priority shows on the two command vectors exactly one edge after the stimulus. If the blanking latch clears too early, the bridge drives during a cycle that should be dark. If it clears too late, the drive stays absent after a legal chopping rise. Either shows at the edge that follows the rise. A wrong previous-flag value shifts the release by one chopping period, so the bench walks the flag through off and on intervals with over-current asserted at different points.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  localparam int NPH = 3;

  typedef struct packed {
    logic [NPH-1:0] hi;
    logic [NPH-1:0] lo;
  } gate_t;

  localparam gate_t GATES_OFF = '{hi: '0, lo: '0};
endpackage

// File: rtl/hall_sector_dec.sv
module hall_sector_dec
  import bldc_pkg::*;
(
  input  logic [NPH-1:0] hall,
  input  logic           dir_fwd,
  output gate_t          drive,
  output logic           valid
);
  logic [NPH-1:0] src;
  logic [NPH-1:0] snk;

  // Forward six-step table: one source and one sink phase per sector.
  always_comb begin
    src = '0;
    snk = '0;
    case (hall)
      3'b001: begin src = 3'b001; snk = 3'b010; end
      3'b011: begin src = 3'b001; snk = 3'b100; end
      3'b010: begin src = 3'b010; snk = 3'b100; end
      3'b110: begin src = 3'b010; snk = 3'b001; end
      3'b100: begin src = 3'b100; snk = 3'b001; end
      3'b101: begin src = 3'b100; snk = 3'b010; end
      default: begin src = '0; snk = '0; end
    endcase
  end

  assign valid = (hall != '0) && (hall != '1);

  // Reverse direction swaps sourced and sunk phase, per phase.
  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign drive.hi[p] = dir_fwd ? src[p] : snk[p];
    assign drive.lo[p] = dir_fwd ? snk[p] : src[p];
  end
endmodule

// File: rtl/oc_blanker.sv
module oc_blanker (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic pwm_on,
  output logic blank
);
  logic pwm_prev_q;
  logic blank_q;
  logic blank_d;
  logic blank_en;
  logic pwm_rise;

  assign pwm_rise = pwm_on & ~pwm_prev_q;

  always_comb begin
    blank_en = oc_flag | (blank_q & pwm_rise);
    blank_d  = oc_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_prev_q <= 1'b0;
      blank_q    <= 1'b0;
    end else begin
      pwm_prev_q <= pwm_on;
      if (blank_en) blank_q <= blank_d;
    end
  end

  assign blank = oc_flag | (blank_q & ~pwm_rise);

  // R10
  oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oc_flag) && !(pwm_on && !$past(pwm_on))) |-> blank);
endmodule

// File: rtl/gate_arbiter.sv
module gate_arbiter
  import bldc_pkg::*;
(
  input  logic  uv_lock,
  input  logic  coast_req,
  input  logic  blank,
  input  logic  brake_req,
  input  logic  valid,
  input  gate_t drive,
  input  logic  pwm_on,
  input  logic  four_quad,
  output gate_t nxt
);
  always_comb begin
    nxt = GATES_OFF;
    if (uv_lock || coast_req || blank) begin
      nxt = GATES_OFF;
    end else if (brake_req) begin
      nxt.hi = '0;
      nxt.lo = pwm_on ? '1 : '0;
    end else if (valid) begin
      nxt.hi = (four_quad && !pwm_on) ? '0 : drive.hi;
      nxt.lo = pwm_on ? drive.lo : '0;
    end
  end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import bldc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hall,
  input  logic           dir_fwd,
  input  logic           brake_req,
  input  logic           coast_req,
  input  logic           four_quad,
  input  logic           pwm_on,
  input  logic           oc_flag,
  input  logic           uv_lock,
  output logic [NPH-1:0] hs_cmd,
  output logic [NPH-1:0] ls_cmd
);
  gate_t drive;
  gate_t nxt;
  gate_t gate_q;
  logic  valid;
  logic  blank;

  hall_sector_dec u_dec (
    .hall    (hall),
    .dir_fwd (dir_fwd),
    .drive   (drive),
    .valid   (valid)
  );

  oc_blanker u_oc (
    .clk     (clk),
    .rst_n   (rst_n),
    .oc_flag (oc_flag),
    .pwm_on  (pwm_on),
    .blank   (blank)
  );

  gate_arbiter u_arb (
    .uv_lock   (uv_lock),
    .coast_req (coast_req),
    .blank     (blank),
    .brake_req (brake_req),
    .valid     (valid),
    .drive     (drive),
    .pwm_on    (pwm_on),
    .four_quad (four_quad),
    .nxt       (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= GATES_OFF;
    else        gate_q <= nxt;
  end

  assign hs_cmd = gate_q.hi;
  assign ls_cmd = gate_q.lo;

  // R11
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_cmd & ls_cmd) == '0) && $onehot0(hs_cmd));
  // R8
  coast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(coast_req) |-> (hs_cmd == '0 && ls_cmd == '0));
  // R9
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uv_lock) |-> (hs_cmd == '0 && ls_cmd == '0));
  // R6
  two_quad_chop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pwm_on && !four_quad) |-> ls_cmd == '0);
  // R7
  four_quad_chop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pwm_on && four_quad) |-> (hs_cmd == '0 && ls_cmd == '0));
  // R4
  bad_hall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!brake_req && (hall == '0 || hall == '1)) |-> (hs_cmd == '0 && ls_cmd == '0));
  // R5
  brake_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(brake_req) |-> hs_cmd == '0);
endmodule

// File: tb/tb_hall_commutator.sv
`timescale 1ns/1ps
module tb_hall_commutator;
  localparam int TCLK = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hall;
  logic       dir_fwd, brake_req, coast_req, four_quad, pwm_on, oc_flag, uv_lock;
  logic [2:0] hs_cmd, ls_cmd;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(TCLK/2) clk = ~clk;

  hall_commutator dut (
    .clk(clk), .rst_n(rst_n), .hall(hall), .dir_fwd(dir_fwd),
    .brake_req(brake_req), .coast_req(coast_req), .four_quad(four_quad),
    .pwm_on(pwm_on), .oc_flag(oc_flag), .uv_lock(uv_lock),
    .hs_cmd(hs_cmd), .ls_cmd(ls_cmd)
  );

  // Forward table from R2: returns {src onehot, sink onehot}.
  function automatic logic [5:0] fwd_pair(input logic [2:0] code);
    case (code)
      3'b001: return {3'b001, 3'b010};
      3'b011: return {3'b001, 3'b100};
      3'b010: return {3'b010, 3'b100};
      3'b110: return {3'b010, 3'b001};
      3'b100: return {3'b100, 3'b001};
      3'b101: return {3'b100, 3'b010};
      default: return 6'b0;
    endcase
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [2:0] eh, input logic [2:0] el);
    n_tests++;
    if (hs_cmd !== eh || ls_cmd !== el) begin
      n_fail++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, hs_cmd, ls_cmd, eh, el);
    end
  endtask

  task automatic idle_inputs();
    hall = 3'b001; dir_fwd = 1'b1; brake_req = 1'b0; coast_req = 1'b0;
    four_quad = 1'b0; pwm_on = 1'b1; oc_flag = 1'b0; uv_lock = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_inputs();
    cyc(); cyc();
    chk("R1 reset outputs", 3'b000, 3'b000);
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_forward();
    logic [2:0] seq [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
    idle_inputs();
    for (int i = 0; i < 6; i++) begin
      logic [5:0] e;
      hall = seq[i];
      e = fwd_pair(seq[i]);
      cyc();
      chk("R2 forward sector", e[5:3], e[2:0]);
      n_tests++;
      if ((hs_cmd & ls_cmd) != 3'b000 || $countones(hs_cmd) > 1) begin
        n_fail++;
        $display("FAIL R11 overlap: hs=%b ls=%b expected disjoint", hs_cmd, ls_cmd);
      end
    end
  endtask

  task automatic t_reverse();
    idle_inputs();
    dir_fwd = 1'b0;
    for (int c = 1; c < 7; c++) begin
      logic [5:0] e;
      hall = 3'(c);
      e = fwd_pair(3'(c));
      cyc();
      chk("R3 reverse sector", e[2:0], e[5:3]);
    end
  endtask

  task automatic t_invalid();
    idle_inputs();
    hall = 3'b000; cyc();
    chk("R4 hall 000", 3'b000, 3'b000);
    hall = 3'b111; cyc();
    chk("R4 hall 111", 3'b000, 3'b000);
  endtask

  task automatic t_brake();
    idle_inputs();
    brake_req = 1'b1; cyc();
    chk("R5 brake pwm on", 3'b000, 3'b111);
    pwm_on = 1'b0; cyc();
    chk("R5 brake pwm off", 3'b000, 3'b000);
    pwm_on = 1'b1; hall = 3'b111; cyc();
    chk("R5 brake bad hall", 3'b000, 3'b111);
  endtask

  task automatic t_quad();
    idle_inputs();
    hall = 3'b110;
    pwm_on = 1'b0; cyc();
    chk("R6 two-quad off interval", 3'b010, 3'b000);
    four_quad = 1'b1; cyc();
    chk("R7 four-quad off interval", 3'b000, 3'b000);
    pwm_on = 1'b1; cyc();
    chk("R7 four-quad on interval", 3'b010, 3'b001);
  endtask

  task automatic t_coast();
    idle_inputs();
    brake_req = 1'b1; coast_req = 1'b1; cyc();
    chk("R8 coast over brake", 3'b000, 3'b000);
    brake_req = 1'b0; cyc();
    chk("R8 coast run", 3'b000, 3'b000);
    coast_req = 1'b0; cyc();
    chk("R8 coast release", 3'b001, 3'b010);
  endtask

  task automatic t_uv();
    idle_inputs();
    uv_lock = 1'b1; brake_req = 1'b1; cyc();
    chk("R9 uv over brake", 3'b000, 3'b000);
    brake_req = 1'b0; cyc();
    chk("R9 uv run", 3'b000, 3'b000);
    uv_lock = 1'b0; cyc();
    chk("R9 uv release", 3'b001, 3'b010);
  endtask

  task automatic t_oc();
    idle_inputs();
    cyc();
    oc_flag = 1'b1; cyc();
    chk("R10 oc immediate", 3'b000, 3'b000);
    oc_flag = 1'b0; cyc();
    chk("R10 oc held, no rise", 3'b000, 3'b000);
    pwm_on = 1'b0; cyc();
    chk("R10 oc held in off interval", 3'b000, 3'b000);
    pwm_on = 1'b1; oc_flag = 1'b1; cyc();
    chk("R10 rise with oc still set", 3'b000, 3'b000);
    oc_flag = 1'b0; cyc();
    chk("R10 held after blocked rise", 3'b000, 3'b000);
    pwm_on = 1'b0; cyc();
    pwm_on = 1'b1; cyc();
    chk("R10 release on clean rise", 3'b001, 3'b010);
    cyc();
    chk("R10 stays released", 3'b001, 3'b010);
  endtask

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_invalid();
    t_brake();
    t_quad();
    t_coast();
    t_uv();
    t_oc();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule